// File: doc/BRIEF.md
# Line Printer Character Stream Formatter

This block sits between a source of 8-bit character codes and a fixed-width line printer. It takes one code at a time over a valid/ready channel and turns it into a stream of printable characters, one character per beat. It keeps its own column counter. It expands horizontal tabs to the next 8-column stop, forces a new line when a line is full, and replaces control codes with spaces.

Line feed and form feed are never printed. Each becomes a request to the downstream vertical-format logic. A line feed raises a line-advance request that carries a count, and a form feed raises a top-of-form request. Each request is handed off with its own valid/ready pair.

A code is accepted only when all the output it caused before has been handed off. This keeps every character, advance and top-of-form request in the order of the input stream.

Top module: `prt_stream_fmt`

## Requirements
- R1: After reset, `in_ready` is high, `out_valid`, `adv_valid` and `tof_valid` are low, and the column counter is 0.
- R2: Only bits 6:0 of `in_code` are used for any decision; bit 7 is ignored.
- R3: Code 0x00 produces no output and leaves the column counter unchanged.
- R4: Code 0x0A produces one line-advance request with `adv_count` equal to 1 and no printable character; the column counter becomes 0.
- R5: Code 0x0C produces one top-of-form request and no printable character; the column counter is unchanged.
- R6: Code 0x0D is emitted unchanged as 0x0D after the column counter is cleared, so the column afterwards is 1.
- R7: Codes 0x01 to 0x1F other than 0x09, 0x0A, 0x0C and 0x0D are emitted as a space (0x20); codes 0x20 to 0x7F are emitted unchanged.
- R8: Code 0x09 at a column below 128 emits 8 minus (column mod 8) spaces.
- R9: Code 0x09 at column 128 or above first issues a one-line advance, which clears the column, and then emits 8 spaces.
- R10: A character other than 0x00, 0x09, 0x0A, 0x0C and 0x0D that arrives at column 132 or above is preceded by a one-line advance; the column never exceeds 132.
- R11: Each printable character handed off increases the column counter by one; each advance handed off sets it to 0.
- R12: `in_ready` is low while any character, advance or top-of-form request is still pending. At most one of `in_ready`, `out_valid`, `adv_valid` and `tof_valid` is high in any cycle. A request that is stalled holds its valid and its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input code valid |
| in_ready | output | 1 | Block can accept a code |
| in_code | input | 8 | Input character code |
| out_valid | output | 1 | Printable character valid |
| out_ready | input | 1 | Downstream takes the character |
| out_char | output | 7 | Printable character |
| adv_valid | output | 1 | Line-advance request |
| adv_ready | input | 1 | Advance request taken |
| adv_count | output | ADV_W | Lines to advance (always 1) |
| tof_valid | output | 1 | Top-of-form request |
| tof_ready | input | 1 | Top-of-form request taken |

## Verification
The bench uses the default parameters: a 132-column line, a tab wrap threshold of 128, 8-column tab stops and an 8-bit column counter. These values put both wrap boundaries within reach of a run of 127 to 133 characters. The bench tests the column on each side of each threshold. It also stalls the character and advance channels with alternating ready patterns, to show that the number and order of beats do not depend on downstream timing.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADV, ST_EMIT, ST_TOF} lpf_state_e;
  typedef enum logic [2:0] {K_DROP, K_LF, K_FF, K_CR, K_TAB, K_CHAR} lpf_kind_e;
  localparam logic [6:0] C_NUL   = 7'h00;
  localparam logic [6:0] C_TAB   = 7'h09;
  localparam logic [6:0] C_LF    = 7'h0A;
  localparam logic [6:0] C_FF    = 7'h0C;
  localparam logic [6:0] C_CR    = 7'h0D;
  localparam logic [6:0] C_SPACE = 7'h20;
endpackage

// File: rtl/lpf_classify.sv
module lpf_classify
  import lpf_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int LINE_COLS = 132,
  parameter int TAB_WRAP  = 128,
  parameter int TAB_STOP  = 8,
  parameter int REP_W     = 4
) (
  input  logic [7:0]       code,
  input  logic [COL_W-1:0] col,
  output lpf_kind_e        kind,
  output logic             pre_adv,
  output logic [REP_W-1:0] rep,
  output logic [6:0]       glyph
);
  logic [6:0]       c7;
  logic [COL_W-1:0] col_mod;

  assign c7      = code[6:0];
  assign col_mod = col % COL_W'(TAB_STOP);

  always_comb begin
    kind    = K_CHAR;
    pre_adv = 1'b0;
    rep     = REP_W'(1);
    glyph   = c7;
    unique case (c7)
      C_NUL: kind = K_DROP;
      C_LF:  kind = K_LF;
      C_FF:  kind = K_FF;
      C_CR:  kind = K_CR;
      C_TAB: begin
        kind  = K_TAB;
        glyph = C_SPACE;
        if (col >= COL_W'(TAB_WRAP)) begin
          pre_adv = 1'b1;
          rep     = REP_W'(TAB_STOP);
        end else begin
          rep = REP_W'(TAB_STOP) - REP_W'(col_mod);
        end
      end
      default: begin
        if (c7 < C_SPACE) glyph = C_SPACE;
        pre_adv = (col >= COL_W'(LINE_COLS));
      end
    endcase
  end
endmodule

// File: rtl/lpf_column.sv
module lpf_column #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] col_q, col_d;
  logic             col_en;

  assign col_en = clr | inc;

  always_comb begin
    col_d = col_q;
    if (clr)      col_d = '0;
    else if (inc) col_d = col_q + COL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_d;
  end

  assign col = col_q;
endmodule

// File: rtl/lpf_sequencer.sv
module lpf_sequencer
  import lpf_pkg::*;
#(
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  lpf_kind_e        kind,
  input  logic             pre_adv,
  input  logic [REP_W-1:0] rep,
  input  logic [6:0]       glyph,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [6:0]       out_char,
  output logic             adv_valid,
  input  logic             adv_ready,
  output logic             tof_valid,
  input  logic             tof_ready,
  output logic             col_clr,
  output logic             col_inc
);
  lpf_state_e       state_q, state_d;
  logic [REP_W-1:0] rem_q, rem_d;
  logic [6:0]       char_q, char_d;
  logic             rem_en, char_en;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    char_d  = char_q;
    rem_en  = 1'b0;
    char_en = 1'b0;
    col_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) begin
        char_d = glyph;
        rem_d  = rep;
        unique case (kind)
          K_LF: begin
            state_d = ST_ADV;
            rem_d   = '0;
            rem_en  = 1'b1;
          end
          K_FF: state_d = ST_TOF;
          K_CR: begin
            state_d = ST_EMIT;
            rem_en  = 1'b1;
            char_en = 1'b1;
            col_clr = 1'b1;
          end
          K_TAB, K_CHAR: begin
            state_d = pre_adv ? ST_ADV : ST_EMIT;
            rem_en  = 1'b1;
            char_en = 1'b1;
          end
          default: state_d = ST_IDLE;
        endcase
      end
      ST_ADV: if (adv_ready) begin
        col_clr = 1'b1;
        state_d = (rem_q != '0) ? ST_EMIT : ST_IDLE;
      end
      ST_EMIT: if (out_ready) begin
        rem_d  = rem_q - REP_W'(1);
        rem_en = 1'b1;
        if (rem_q == REP_W'(1)) state_d = ST_IDLE;
      end
      ST_TOF: if (tof_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en)  rem_q  <= rem_d;
      if (char_en) char_q <= char_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_EMIT);
  assign adv_valid = (state_q == ST_ADV);
  assign tof_valid = (state_q == ST_TOF);
  assign out_char  = char_q;
  assign col_inc   = out_valid & out_ready;
endmodule

// File: rtl/prt_stream_fmt.sv
module prt_stream_fmt
  import lpf_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int LINE_COLS = 132,
  parameter int TAB_WRAP  = 128,
  parameter int TAB_STOP  = 8,
  parameter int ADV_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_code,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [6:0]       out_char,
  output logic             adv_valid,
  input  logic             adv_ready,
  output logic [ADV_W-1:0] adv_count,
  output logic             tof_valid,
  input  logic             tof_ready
);
  localparam int REP_W = $clog2(TAB_STOP + 1);

  logic [COL_W-1:0] col_q;
  lpf_kind_e        kind;
  logic             pre_adv;
  logic [REP_W-1:0] rep;
  logic [6:0]       glyph;
  logic             col_clr, col_inc;

  lpf_classify #(
    .COL_W(COL_W), .LINE_COLS(LINE_COLS), .TAB_WRAP(TAB_WRAP),
    .TAB_STOP(TAB_STOP), .REP_W(REP_W)
  ) u_classify (
    .code(in_code), .col(col_q), .kind(kind), .pre_adv(pre_adv),
    .rep(rep), .glyph(glyph)
  );

  lpf_sequencer #(.REP_W(REP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .kind(kind), .pre_adv(pre_adv), .rep(rep), .glyph(glyph),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char),
    .adv_valid(adv_valid), .adv_ready(adv_ready),
    .tof_valid(tof_valid), .tof_ready(tof_ready),
    .col_clr(col_clr), .col_inc(col_inc)
  );

  lpf_column #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(col_clr), .inc(col_inc), .col(col_q)
  );

  assign adv_count = ADV_W'(1);
endmodule

// File: rtl/lpf_checker.sv
module lpf_checker #(
  parameter int COL_W     = 8,
  parameter int LINE_COLS = 132,
  parameter int ADV_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [6:0]       out_char,
  input logic             adv_valid,
  input logic             adv_ready,
  input logic [ADV_W-1:0] adv_count,
  input logic             tof_valid,
  input logic [COL_W-1:0] col
);
  assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid, adv_valid, tof_valid}));

  assert_char_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_char));

  assert_adv_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid && !adv_ready |=> adv_valid);

  assert_adv_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid |-> adv_count == ADV_W'(1));

  assert_printable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_char >= 7'h20 || out_char == 7'h0D));

  assert_col_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_W'(LINE_COLS));

  assert_col_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> col == COL_W'($past(col) + COL_W'(1)));

  assert_adv_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid && adv_ready |=> col == '0);
endmodule

bind prt_stream_fmt lpf_checker #(
  .COL_W(COL_W), .LINE_COLS(LINE_COLS), .ADV_W(ADV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_char(out_char), .adv_valid(adv_valid),
  .adv_ready(adv_ready), .adv_count(adv_count), .tof_valid(tof_valid),
  .col(col_q)
);

// File: tb/prt_stream_fmt_tb.sv
`timescale 1ns/1ps
module prt_stream_fmt_tb;
  localparam logic [1:0] EV_C = 2'd0, EV_A = 2'd1, EV_T = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_code = 8'h00;
  logic       out_ready = 1'b1, adv_ready = 1'b1, tof_ready = 1'b1;
  logic       in_ready, out_valid, adv_valid, tof_valid;
  logic [6:0] out_char;
  logic [3:0] adv_count;

  int checks = 0, fails = 0, overlap = 0, ev_n = 0;
  logic [1:0] ev_k [0:1023];
  logic [6:0] ev_c [0:1023];
  logic       bp_on = 1'b0;
  logic [1:0] bp_cnt = 2'd0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  prt_stream_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_char(out_char), .adv_valid(adv_valid), .adv_ready(adv_ready),
    .adv_count(adv_count), .tof_valid(tof_valid), .tof_ready(tof_ready)
  );

  // handshakes seen at the negedge complete at the following posedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && (out_valid || adv_valid || tof_valid)) overlap++;
      if (out_valid && out_ready) begin
        ev_k[ev_n] = EV_C; ev_c[ev_n] = out_char; ev_n++;
      end else if (adv_valid && adv_ready) begin
        ev_k[ev_n] = EV_A; ev_c[ev_n] = 7'(adv_count); ev_n++;
      end else if (tof_valid && tof_ready) begin
        ev_k[ev_n] = EV_T; ev_c[ev_n] = 7'h00; ev_n++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    bp_cnt = bp_cnt + 2'd1;
    if (bp_on) begin
      out_ready = bp_cnt[0];
      adv_ready = bp_cnt[1];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ev(input int idx, input logic [1:0] k, input logic [6:0] c, input string req);
    int act;
    act = (idx < ev_n) ? int'({ev_k[idx], ev_c[idx]}) : -1;
    check(idx < ev_n && ev_k[idx] == k && ev_c[idx] == c, req, act, int'({k, c}));
  endtask

  task automatic chk_run(input int from, input int n, input logic [6:0] c, input string req);
    int bad = 0;
    for (int i = from; i < from + n; i++)
      if (i >= ev_n || ev_k[i] != EV_C || ev_c[i] != c) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; bp_on = 1'b0;
    out_ready = 1'b1; adv_ready = 1'b1; tof_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    ev_n = 0;
  endtask

  task automatic send(input logic [7:0] code);
    @(posedge clk); #2;
    in_valid = 1'b1; in_code = code;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic send_n(input logic [7:0] code, input int n);
    for (int i = 0; i < n; i++) send(code);
  endtask

  task automatic settle();
    do @(negedge clk); while (!in_ready);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(in_ready && !out_valid && !adv_valid && !tof_valid, "R1 reset outputs",
          {in_ready, out_valid, adv_valid, tof_valid}, 4'b1000);
    send(8'h09); settle();
    check(ev_n == 8, "R1 column zero after reset", ev_n, 8);
  endtask

  task automatic t_nul_mask();
    do_reset();
    send(8'h00); send(8'h80); settle();
    check(ev_n == 0, "R3 NUL discarded", ev_n, 0);
    send(8'hC1); send(8'h8A); settle();
    chk_ev(0, EV_C, 7'h41, "R2 high bit ignored on printable");
    chk_ev(1, EV_A, 7'd1, "R2 high bit ignored on LF");
    do_reset();
    send(8'h41); send(8'h00); send(8'h09); settle();
    check(ev_n == 8, "R3 NUL keeps column", ev_n, 8);
  endtask

  task automatic t_lf_ff();
    do_reset();
    send(8'h41); send(8'h42); send(8'h43); send(8'h0A); send(8'h09); settle();
    chk_ev(3, EV_A, 7'd1, "R4 LF advance count 1");
    check(ev_n == 12, "R4 LF clears column, not printed", ev_n, 12);
    do_reset();
    send(8'h61); send(8'h62); send(8'h0C); send(8'h09); settle();
    chk_ev(2, EV_T, 7'h00, "R5 FF top-of-form");
    check(ev_n == 9, "R5 FF keeps column", ev_n, 9);
  endtask

  task automatic t_cr_ctrl();
    do_reset();
    send_n(8'h58, 3); send(8'h0D); send(8'h09); settle();
    chk_ev(3, EV_C, 7'h0D, "R6 CR emitted");
    check(ev_n == 11, "R6 column 1 after CR", ev_n, 11);
    do_reset();
    send(8'h01); send(8'h1F); send(8'h7F); send(8'h20); send(8'h0B); settle();
    chk_ev(0, EV_C, 7'h20, "R7 0x01 to space");
    chk_ev(1, EV_C, 7'h20, "R7 0x1F to space");
    chk_ev(2, EV_C, 7'h7F, "R7 0x7F unchanged");
    chk_ev(4, EV_C, 7'h20, "R7 0x0B to space");
  endtask

  task automatic t_tab();
    do_reset();
    send(8'h09); send_n(8'h61, 3); send(8'h09); settle();
    chk_run(0, 8, 7'h20, "R8 tab from column 0");
    check(ev_n == 16, "R8 tab from column 11", ev_n, 16);
    do_reset();
    send_n(8'h78, 127); send(8'h09); settle();
    check(ev_n == 128 && ev_c[127] == 7'h20, "R8 tab at column 127 one space", ev_n, 128);
    send(8'h09); send(8'h09); settle();
    chk_ev(128, EV_A, 7'd1, "R9 tab at 128 advances first");
    chk_run(129, 8, 7'h20, "R9 eight spaces after advance");
    check(ev_n == 145, "R9 column 8 after wrapped tab", ev_n, 145);
  endtask

  task automatic t_wrap();
    do_reset();
    send_n(8'h61, 132); settle();
    check(ev_n == 132, "R10 no advance up to 132", ev_n, 132);
    chk_run(0, 132, 7'h61, "R11 full line emitted");
    send(8'h62); send(8'h09); settle();
    chk_ev(132, EV_A, 7'd1, "R10 advance before char 133");
    chk_ev(133, EV_C, 7'h62, "R10 char after advance");
    check(ev_n == 141, "R11 column 1 after wrap", ev_n, 141);
  endtask

  task automatic t_backpressure();
    do_reset();
    bp_on = 1'b1;
    send(8'h09); send(8'h0A); send(8'h51); send(8'h0C); settle();
    bp_on = 1'b0; out_ready = 1'b1; adv_ready = 1'b1;
    chk_run(0, 8, 7'h20, "R12 tab under stall");
    chk_ev(8, EV_A, 7'd1, "R12 LF under stall");
    chk_ev(9, EV_C, 7'h51, "R12 char under stall");
    chk_ev(10, EV_T, 7'h00, "R12 FF order kept");
    check(overlap == 0, "R12 ready low while pending", overlap, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nul_mask();
    t_lf_ff();
    t_cr_ctrl();
    t_tab();
    t_wrap();
    t_backpressure();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule